// File: doc/BRIEF.md
# Banked Logical-to-Physical Address Translator

This block widens a 16-bit CPU logical address into a 20-bit physical address. The logical space is cut into up to three windows: a low window that is passed through unchanged, a middle "bank" window and a top "upper common" window. The two upper windows each add their own page-granular offset to the address. The translation is combinational, so every memory access is translated in the same cycle in which its logical address appears.

Software sets up the translator through a small port-mapped register bus. The bus has a port number, a write strobe, a read strobe and 8-bit data. There are three 8-bit registers:

- A boundary register. Its low nibble (bits 3:0) gives the first 4 KB page of the bank window. Its high nibble (bits 7:4) gives the first 4 KB page of the upper common window.
- A bank page register.
- An upper page register.

Each page register is multiplied by 4096 and added to the logical address when its window is selected.

Top module: `bank_xlate`

## Requirements
- R1: After reset, the boundary register reads 0xF0 and both page registers read 0x00. With these values, logical 0x1000 maps to 0x01000 and logical 0xF800 maps to 0x0F800.
- R2: A write with `io_wr` high and `io_port` equal to a register's port updates that register at the next rising clock edge. The default ports are 0x10 for the boundary register, 0x11 for the bank page register and 0x12 for the upper page register. A later read of the same port returns the written byte.
- R3: Two kinds of write leave all three registers and the translation unchanged: a write strobe on a port that matches no register, and data presented on a register port while `io_wr` is low.
- R4: `io_rdata` is 0x00 whenever `io_rd` is low, and also when `io_rd` is high with an unmapped port.
- R5: When the top nibble of the logical address is below both boundary nibbles, the physical address is the logical address zero-extended to 20 bits.
- R6: When the top nibble is at least the bank nibble (bits 3:0) and below the upper nibble (bits 7:4), the physical address is logical + bank page × 4096. For example, with 0xA8, bank 0x10 and logical 0x8000, the result is 0x18000.
- R7: When the top nibble is at least the upper nibble, the physical address is logical + upper page × 4096. The low 12 address bits always pass through unchanged.
- R8: The upper window is tested before the bank window. A boundary value whose upper nibble is below its bank nibble therefore still gives a fixed mapping: the upper window wins wherever both comparisons hold.
- R9: The 20-bit sum wraps modulo 2^20.
- R10: Equal nibbles remove the bank window. With both nibbles zero, the whole logical space uses the upper page register.
- R11: The physical address follows a change of the logical address within the same cycle, with no register in the path.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_port | input | 8 | Register port number |
| io_wr | input | 1 | Register write strobe |
| io_rd | input | 1 | Register read strobe |
| io_wdata | input | 8 | Register write data |
| io_rdata | output | 8 | Register read data, zero when not reading a mapped port |
| log_addr | input | 16 | CPU logical address |
| phys_addr | output | 20 | Translated physical address |

## Verification
The bench builds the block with its default parameters: 16-bit logical, 20-bit physical, 4-bit boundary nibbles and ports 0x10 to 0x12. These widths make both wrap-around at 2^20 and every boundary nibble value reachable with a handful of register writes.

The bench checks four layouts:
- three windows (0xA8);
- equal nibbles (0x66);
- all-upper (0x00);
- inverted nibbles (0x4C).

Page offsets near 0xFF are used so that a missing truncation or a swapped register would show at the output.

// File: rtl/bank_xlate_pkg.sv
package bank_xlate_pkg;

  // Register indices inside the register file
  localparam int REG_BOUND = 0;
  localparam int REG_BANK  = 1;
  localparam int REG_UPPER = 2;
  localparam int NUM_REGS  = 3;

  // Window indices of the one-hot select vector
  localparam int WIN_LOW   = 0;
  localparam int WIN_BANK  = 1;
  localparam int WIN_UPPER = 2;
  localparam int NUM_WINS  = 3;

  typedef enum logic [1:0] {
    WIN_SEL_LOW   = 2'd0,
    WIN_SEL_BANK  = 2'd1,
    WIN_SEL_UPPER = 2'd2
  } win_e;

endpackage

// File: rtl/bx_regfile.sv
module bx_regfile
  import bank_xlate_pkg::*;
#(
  parameter int PORT_W = 8,
  parameter int DATA_W = 8,
  parameter logic [PORT_W-1:0] BOUND_PORT = 8'h10,
  parameter logic [PORT_W-1:0] BANK_PORT  = 8'h11,
  parameter logic [PORT_W-1:0] UPPER_PORT = 8'h12,
  parameter logic [DATA_W-1:0] BOUND_RST  = 8'hF0,
  parameter logic [DATA_W-1:0] BANK_RST   = 8'h00,
  parameter logic [DATA_W-1:0] UPPER_RST  = 8'h00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PORT_W-1:0] io_port,
  input  logic              io_wr,
  input  logic              io_rd,
  input  logic [DATA_W-1:0] io_wdata,
  output logic [DATA_W-1:0] io_rdata,
  output logic [DATA_W-1:0] bound_q,
  output logic [DATA_W-1:0] bank_q,
  output logic [DATA_W-1:0] upper_q
);

  localparam logic [PORT_W-1:0] PORT_TAB [NUM_REGS] = '{BOUND_PORT, BANK_PORT, UPPER_PORT};
  localparam logic [DATA_W-1:0] RST_TAB  [NUM_REGS] = '{BOUND_RST, BANK_RST, UPPER_RST};

  logic [DATA_W-1:0] regs_q [NUM_REGS];
  logic [NUM_REGS-1:0] port_hit;
  logic [NUM_REGS-1:0] wr_hit;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    assign port_hit[g] = (io_port == PORT_TAB[g]);
    assign wr_hit[g]   = io_wr && port_hit[g];

    always_ff @(posedge clk) begin
      if (!rst_n)
        regs_q[g] <= RST_TAB[g];
      else if (wr_hit[g])
        regs_q[g] <= io_wdata;
    end

    // R2: an accepted write lands on the following edge
    assert_wr_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_hit[g] |=> (regs_q[g] == $past(io_wdata)));

    // R3: without a matching write strobe the register keeps its value
    assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_hit[g] |=> $stable(regs_q[g]));
  end

  always_comb begin
    io_rdata = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (io_rd && port_hit[i])
        io_rdata = io_rdata | regs_q[i];
    end
  end

  assign bound_q = regs_q[REG_BOUND];
  assign bank_q  = regs_q[REG_BANK];
  assign upper_q = regs_q[REG_UPPER];

  // R4: the read bus is quiet while no read strobe is present
  assert_rd_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !io_rd |-> (io_rdata == '0));

endmodule

// File: rtl/bx_win_decode.sv
module bx_win_decode
  import bank_xlate_pkg::*;
#(
  parameter int NIB_W = 4
) (
  input  logic [NIB_W-1:0]    page_nib,
  input  logic [NIB_W-1:0]    bank_nib,
  input  logic [NIB_W-1:0]    upper_nib,
  output win_e                win,
  output logic [NUM_WINS-1:0] win_hot
);

  // Upper window has priority; then bank; low window otherwise.
  function automatic win_e pick_win(input logic [NIB_W-1:0] pg,
                                    input logic [NIB_W-1:0] bk,
                                    input logic [NIB_W-1:0] up);
    if (pg >= up)      return WIN_SEL_UPPER;
    else if (pg >= bk) return WIN_SEL_BANK;
    else               return WIN_SEL_LOW;
  endfunction

  assign win = pick_win(page_nib, bank_nib, upper_nib);

  always_comb begin
    win_hot = '0;
    unique case (win)
      WIN_SEL_UPPER: win_hot[WIN_UPPER] = 1'b1;
      WIN_SEL_BANK:  win_hot[WIN_BANK]  = 1'b1;
      default:       win_hot[WIN_LOW]   = 1'b1;
    endcase
  end

endmodule

// File: rtl/bx_offset_add.sv
module bx_offset_add
  import bank_xlate_pkg::*;
#(
  parameter int LA_W   = 16,
  parameter int PA_W   = 20,
  parameter int DATA_W = 8,
  parameter int NIB_W  = 4
) (
  input  logic [LA_W-1:0]     log_addr,
  input  logic [NUM_WINS-1:0] win_hot,
  input  logic [DATA_W-1:0]   bank_pg,
  input  logic [DATA_W-1:0]   upper_pg,
  output logic [PA_W-1:0]     phys_addr
);

  localparam int PAGE_SH = LA_W - NIB_W;

  // Page register placed above the in-page bits, sum truncated to PA_W
  function automatic logic [PA_W-1:0] add_page(input logic [LA_W-1:0] la,
                                               input logic [DATA_W-1:0] pg);
    logic [PA_W-1:0] ext_la;
    logic [PA_W-1:0] ext_pg;
    ext_la = PA_W'(la);
    ext_pg = PA_W'(pg) << PAGE_SH;
    return ext_la + ext_pg;
  endfunction

  logic [PA_W-1:0] sum_bank;
  logic [PA_W-1:0] sum_upper;
  logic [PA_W-1:0] pass_low;

  assign sum_bank  = add_page(log_addr, bank_pg);
  assign sum_upper = add_page(log_addr, upper_pg);
  assign pass_low  = PA_W'(log_addr);

  always_comb begin
    phys_addr = pass_low;
    if (win_hot[WIN_UPPER])     phys_addr = sum_upper;
    else if (win_hot[WIN_BANK]) phys_addr = sum_bank;
  end

endmodule

// File: rtl/bank_xlate.sv
module bank_xlate
  import bank_xlate_pkg::*;
#(
  parameter int LA_W   = 16,
  parameter int PA_W   = 20,
  parameter int PORT_W = 8,
  parameter int NIB_W  = 4,
  parameter logic [PORT_W-1:0] BOUND_PORT = 8'h10,
  parameter logic [PORT_W-1:0] BANK_PORT  = 8'h11,
  parameter logic [PORT_W-1:0] UPPER_PORT = 8'h12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PORT_W-1:0] io_port,
  input  logic              io_wr,
  input  logic              io_rd,
  input  logic [2*NIB_W-1:0] io_wdata,
  output logic [2*NIB_W-1:0] io_rdata,
  input  logic [LA_W-1:0]   log_addr,
  output logic [PA_W-1:0]   phys_addr
);

  localparam int DATA_W  = 2 * NIB_W;
  localparam int PAGE_SH = LA_W - NIB_W;

  logic [DATA_W-1:0]   bound_q;
  logic [DATA_W-1:0]   bank_q;
  logic [DATA_W-1:0]   upper_q;
  logic [NIB_W-1:0]    page_nib;
  logic [NIB_W-1:0]    bank_nib;
  logic [NIB_W-1:0]    upper_nib;
  win_e                win;
  logic [NUM_WINS-1:0] win_hot;

  bx_regfile #(
    .PORT_W     (PORT_W),
    .DATA_W     (DATA_W),
    .BOUND_PORT (BOUND_PORT),
    .BANK_PORT  (BANK_PORT),
    .UPPER_PORT (UPPER_PORT),
    .BOUND_RST  (DATA_W'(8'hF0)),
    .BANK_RST   ('0),
    .UPPER_RST  ('0)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .io_port  (io_port),
    .io_wr    (io_wr),
    .io_rd    (io_rd),
    .io_wdata (io_wdata),
    .io_rdata (io_rdata),
    .bound_q  (bound_q),
    .bank_q   (bank_q),
    .upper_q  (upper_q)
  );

  assign page_nib  = log_addr[LA_W-1 -: NIB_W];
  assign bank_nib  = bound_q[NIB_W-1:0];
  assign upper_nib = bound_q[DATA_W-1:NIB_W];

  bx_win_decode #(
    .NIB_W (NIB_W)
  ) u_decode (
    .page_nib  (page_nib),
    .bank_nib  (bank_nib),
    .upper_nib (upper_nib),
    .win       (win),
    .win_hot   (win_hot)
  );

  bx_offset_add #(
    .LA_W   (LA_W),
    .PA_W   (PA_W),
    .DATA_W (DATA_W),
    .NIB_W  (NIB_W)
  ) u_add (
    .log_addr  (log_addr),
    .win_hot   (win_hot),
    .bank_pg   (bank_q),
    .upper_pg  (upper_q),
    .phys_addr (phys_addr)
  );

  // R8: exactly one window is chosen for any register contents
  assert_one_win_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(win_hot));

  // R5: low window output equals the zero-extended input
  assert_low_pass_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (win == WIN_SEL_LOW) |-> (phys_addr == PA_W'(log_addr)));

  // R7: offsets are page granular, so in-page bits never change
  assert_inpage_R7: assert property (@(posedge clk) disable iff (!rst_n)
    phys_addr[PAGE_SH-1:0] == log_addr[PAGE_SH-1:0]);

  // R10: a page below both equal nibbles can only be the low window
  assert_no_bank_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_nib == upper_nib) |-> (win != WIN_SEL_BANK));

endmodule

// File: tb/bank_xlate_tb.sv
module bank_xlate_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  io_port = 8'h00;
  logic        io_wr = 1'b0;
  logic        io_rd = 1'b0;
  logic [7:0]  io_wdata = 8'h00;
  logic [7:0]  io_rdata;
  logic [15:0] log_addr = 16'h0000;
  logic [19:0] phys_addr;

  always #5 clk = ~clk;

  bank_xlate u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .io_port   (io_port),
    .io_wr     (io_wr),
    .io_rd     (io_rd),
    .io_wdata  (io_wdata),
    .io_rdata  (io_rdata),
    .log_addr  (log_addr),
    .phys_addr (phys_addr)
  );

  typedef struct {
    bit         is_rd;
    logic [19:0] exp;
    string      tag;
  } item_t;

  item_t q[$];
  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  // bench-side register model
  logic [7:0] m_bound = 8'hF0;
  logic [7:0] m_bank  = 8'h00;
  logic [7:0] m_upper = 8'h00;

  function automatic logic [19:0] ref_map(input logic [15:0] la);
    int pg;
    int addr;
    pg = int'(la) / 4096;
    addr = int'(la);
    if (pg >= int'(m_bound[7:4]))      addr = addr + int'(m_upper) * 4096;
    else if (pg >= int'(m_bound[3:0])) addr = addr + int'(m_bank) * 4096;
    return 20'(addr % 1048576);
  endfunction

  task automatic drive(input bit wr, input bit rd, input logic [7:0] port,
                       input logic [7:0] data, input logic [15:0] la);
    @(negedge clk);
    io_wr = wr; io_rd = rd; io_port = port; io_wdata = data; log_addr = la;
  endtask

  task automatic wr_reg(input logic [7:0] port, input logic [7:0] data);
    drive(1'b1, 1'b0, port, data, log_addr);
    if (port == 8'h10) m_bound = data;
    if (port == 8'h11) m_bank  = data;
    if (port == 8'h12) m_upper = data;
  endtask

  task automatic chk_rd(input bit rd, input logic [7:0] port,
                        input logic [7:0] exp, input string tag);
    item_t it;
    drive(1'b0, rd, port, 8'h00, log_addr);
    it.is_rd = 1'b1; it.exp = 20'(exp); it.tag = tag;
    q.push_back(it);
  endtask

  task automatic chk_xl(input logic [15:0] la, input logic [19:0] exp, input string tag);
    item_t it;
    drive(1'b0, 1'b0, 8'h00, 8'h00, la);
    if (ref_map(la) != exp) begin
      n_fail++;
      $display("FAIL %s model actual=%05h expected=%05h", tag, ref_map(la), exp);
    end
    it.is_rd = 1'b0; it.exp = exp; it.tag = tag;
    q.push_back(it);
  endtask

  // monitor: compares results away from the active edge
  initial begin
    forever begin
      @(negedge clk);
      #3;
      while (q.size() > 0) begin
        item_t it;
        logic [19:0] act;
        it = q.pop_front();
        act = it.is_rd ? 20'(io_rdata) : phys_addr;
        n_chk++;
        if (act !== it.exp) begin
          n_fail++;
          $display("FAIL %s actual=%05h expected=%05h", it.tag, act, it.exp);
        end
      end
    end
  end

  initial begin
    #500000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset values and default mapping
    chk_rd(1'b1, 8'h10, 8'hF0, "R1 bound reset");
    chk_rd(1'b1, 8'h11, 8'h00, "R1 bank reset");
    chk_rd(1'b1, 8'h12, 8'h00, "R1 upper reset");
    chk_xl(16'h1000, 20'h01000, "R1 map 1000");
    chk_xl(16'hF800, 20'h0F800, "R1 map F800");

    // R2 writes and readback
    wr_reg(8'h10, 8'hA8);
    wr_reg(8'h11, 8'h10);
    wr_reg(8'h12, 8'h40);
    chk_rd(1'b1, 8'h10, 8'hA8, "R2 bound readback");
    chk_rd(1'b1, 8'h11, 8'h10, "R2 bank readback");
    chk_rd(1'b1, 8'h12, 8'h40, "R2 upper readback");

    // R5 R6 R7 three-window layout, R11 same-cycle response
    chk_xl(16'h7FFF, 20'h07FFF, "R5 low top");
    chk_xl(16'h0000, 20'h00000, "R5 low bottom");
    chk_xl(16'h8000, 20'h18000, "R6 bank start");
    chk_xl(16'h9FFF, 20'h19FFF, "R6 bank end");
    chk_xl(16'hA000, 20'h4A000, "R7 upper start");
    chk_xl(16'hFFFF, 20'h4FFFF, "R11 R7 upper end");

    // R4 quiet read bus
    chk_rd(1'b0, 8'h10, 8'h00, "R4 no strobe");
    chk_rd(1'b1, 8'h13, 8'h00, "R4 unmapped read");

    // R3 ignored writes
    drive(1'b1, 1'b0, 8'h13, 8'h55, 16'h0000);
    drive(1'b0, 1'b0, 8'h10, 8'h00, 16'h0000);
    drive(1'b0, 1'b0, 8'h11, 8'hEE, 16'h0000);
    chk_rd(1'b1, 8'h10, 8'hA8, "R3 bound kept");
    chk_rd(1'b1, 8'h11, 8'h10, "R3 bank kept");
    chk_rd(1'b1, 8'h12, 8'h40, "R3 upper kept");
    chk_xl(16'h8123, 20'h18123, "R3 map kept");

    // R9 wrap-around
    wr_reg(8'h11, 8'hF8);
    wr_reg(8'h12, 8'hFF);
    chk_xl(16'h8000, 20'h00000, "R9 bank wrap");
    chk_xl(16'hFFFF, 20'h0EFFF, "R9 upper wrap");

    // R10 equal nibbles
    wr_reg(8'h10, 8'h66);
    chk_xl(16'h5FFF, 20'h05FFF, "R10 equal low");
    chk_xl(16'h6000, 20'h05000, "R10 equal upper");
    wr_reg(8'h10, 8'h00);
    chk_xl(16'h0123, 20'hFF123, "R10 all upper");

    // R8 inverted nibbles
    wr_reg(8'h10, 8'h4C);
    chk_xl(16'h3000, 20'h03000, "R8 below both");
    chk_xl(16'h5000, 20'h04000, "R8 upper wins");
    chk_xl(16'hD000, 20'h0C000, "R8 upper over bank");

    drive(1'b0, 1'b0, 8'h00, 8'h00, 16'h0000);
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule